// File: doc/BRIEF.md
# Configurable Digital Downconverter Chain

This block takes a stream of real, signed intermediate-frequency samples, as they come from an ADC, and turns them into a complex baseband stream at a lower rate. A numerically controlled oscillator holds a phase accumulator that a programmable frequency word advances on every accepted sample. A quarter-wave folded lookup turns the phase into cosine and sine. A complex mixer multiplies the input sample by cosine and by negated sine, so a carrier at the oscillator frequency is moved to 0 Hz.

After the mixer come identical stages in cascade. Each stage has an 11-tap half-band low-pass filter followed by a keep-one-in-two decimator. Any stage can be switched to a plain one-register pass-through, so the total decimation can be set at run time to any power of two up to 2^N_STAGES. The mixer can also be bypassed, and the output can be made real-only, which forces the quadrature lane to zero.

Top module: `ddc_chain`

## Requirements
- R1: While reset is held and right after it is released, out_valid is 0 and out_i and out_q are 0.
- R2: With the mixer enabled, frequency word 2^28 (one sixteenth of the sample rate) and stages 0 to 2 active, an input tone A·cos(2πn/16) with A = 20000 settles to out_i within 10000 ± 150 and out_q within 0 ± 150. Consecutive outputs differ by no more than 60.
- R3: An active stage raises its output valid for the 1st, 3rd, 5th and each further odd input valid counted from reset. With k active stages and N input samples after reset, the chain produces N/2^k outputs; with one stage, 65 inputs give 33 outputs.
- R4: A bypassed stage forwards each input sample unchanged, one clock later, with its valid. With the mixer bypassed and all stages bypassed, each input appears on out_i exactly 5 clocks after the edge that accepts it.
- R5: With cfg_mix_en = 0 the mixer passes the input sample to the in-phase lane and puts 0 on the quadrature lane.
- R6: A single active stage attenuates a real tone at 0.45 of its input rate by at least 40 dB: with amplitude 16000, the settled output magnitude stays at or below 160.
- R7: A single active stage passes a real tone at 1/40 of its input rate: with amplitude 16000, the settled output peak is at least 15200.
- R8: Filter results are rounded to nearest and saturated to 16 bits. With taps 3, -25, 150, 256, 150, -25, 3 (over 512) at the even offsets and the centre, a window matching the coefficient signs at amplitude 32767 yields 32767, and the negated window yields -32768.
- R9: With cfg_real_only = 1, out_q is 0 on every output while out_i behaves as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed real input sample |
| cfg_fcw | input | 32 | Oscillator frequency word added to the phase per sample |
| cfg_mix_en | input | 1 | 1 = mix with the oscillator, 0 = pass-through |
| cfg_stage_en | input | 4 | Per-stage enable, bit 0 is the first stage after the mixer |
| cfg_real_only | input | 1 | 1 = force out_q to zero |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Signed in-phase output |
| out_q | output | 16 | Signed quadrature output |

## Verification
The bench uses the default parameters: a 32-bit phase, a 1024-point wave table and four stages. Four stages allow decimation from 1 up to 16 and a worst-case bypass latency of five registers. With a frequency word of 2^28, the oscillator phase steps by exactly 64 table points per sample, so the tone at the oscillator frequency has a known DC result. With three stages active, the mixing image lands on the exact zero of the third stage's response at half its rate. A single active stage, with the mixer off, exposes the raw half-band response, so stopband rejection, passband gain and saturation can be measured on one filter in isolation.

// File: rtl/ddc_pkg.sv
`timescale 1ns/1ps
package ddc_pkg;
    localparam int DW = 16;
    localparam int AW = 40;

    typedef logic signed [DW-1:0] sample_t;
    typedef logic signed [AW-1:0] acc_t;

    localparam acc_t SMAX = acc_t'((1 << (DW-1)) - 1);
    localparam acc_t SMIN = -acc_t'(1 << (DW-1));

    // half-band coefficients, scaled by 2^HB_SH
    localparam acc_t HB_C1 = acc_t'(3);
    localparam acc_t HB_C3 = acc_t'(-25);
    localparam acc_t HB_C5 = acc_t'(150);
    localparam acc_t HB_CC = acc_t'(256);
    localparam int unsigned HB_SH  = 9;
    localparam int unsigned MIX_SH = DW - 1;

    function automatic acc_t sx(input sample_t v);
        return acc_t'(v);
    endfunction

    // round half up then clamp to sample range
    function automatic sample_t rnd_sat(input acc_t v, input int unsigned sh);
        acc_t r;
        r = (v + (acc_t'(1) <<< (sh - 1))) >>> sh;
        if (r > SMAX) return sample_t'(SMAX);
        if (r < SMIN) return sample_t'(SMIN);
        return sample_t'(r);
    endfunction
endpackage

// File: rtl/ddc_nco.sv
`timescale 1ns/1ps
module ddc_nco
    import ddc_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int LUT_AW  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic [PHASE_W-1:0] fcw,
    output sample_t            cos_o,
    output sample_t            sin_o
);
    localparam int     QAW  = LUT_AW - 2;
    localparam int     QN   = 1 << QAW;
    localparam longint HALF = longint'(1) << LUT_AW;
    localparam longint AMP  = (longint'(1) << (DW - 1)) - 1;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } st_t;

    st_t st_d, st_q;

    // rational sine approximation at half-point offsets, first quadrant
    function automatic longint quarter_sine(input int k);
        longint t;
        longint u;
        t = 2 * longint'(k) + 1;
        u = t * (HALF - t);
        return (16 * u * AMP) / (5 * HALF * HALF - 4 * u);
    endfunction

    sample_t lut [QN];
    for (genvar k = 0; k < QN; k++) begin : g_lut
        assign lut[k] = sample_t'(quarter_sine(k));
    end

    logic [LUT_AW-1:0] ps, pc;
    logic [QAW-1:0]    si, ci;

    always_comb begin
        ps = st_q.phase[PHASE_W-1 -: LUT_AW];
        pc = ps + LUT_AW'(QN);
        si = ps[LUT_AW-2] ? ~ps[QAW-1:0] : ps[QAW-1:0];
        ci = pc[LUT_AW-2] ? ~pc[QAW-1:0] : pc[QAW-1:0];
        sin_o = ps[LUT_AW-1] ? -lut[si] : lut[si];
        cos_o = pc[LUT_AW-1] ? -lut[ci] : lut[ci];
    end

    always_comb begin
        st_d = st_q;
        if (step) st_d.phase = st_q.phase + fcw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ddc_mixer.sv
`timescale 1ns/1ps
module ddc_mixer
    import ddc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid,
    input  sample_t x,
    input  logic    mix_en,
    input  sample_t nco_cos,
    input  sample_t nco_sin,
    output logic    out_valid,
    output sample_t out_i,
    output sample_t out_q
);
    typedef struct packed {
        logic    vld;
        sample_t i;
        sample_t q;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (mix_en) begin
                st_d.i = rnd_sat(sx(x) * sx(nco_cos), MIX_SH);
                st_d.q = rnd_sat(-(sx(x) * sx(nco_sin)), MIX_SH);
            end else begin
                st_d.i = x;
                st_d.q = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_i     = st_q.i;
    assign out_q     = st_q.q;

    // R5: bypassed mixer forwards the real sample and zeroes quadrature
    p_mix_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mix_en && in_valid) |=> (out_valid && out_q == '0 && out_i == $past(x)));
endmodule

// File: rtl/ddc_hb_stage.sv
`timescale 1ns/1ps
module ddc_hb_stage
    import ddc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    bypass,
    input  logic    in_valid,
    input  sample_t in_i,
    input  sample_t in_q,
    output logic    out_valid,
    output sample_t out_i,
    output sample_t out_q
);
    localparam int TAPS = 11;
    localparam int CTR  = (TAPS - 1) / 2;

    typedef struct packed {
        logic                   phase;
        logic                   vld;
        sample_t                oi;
        sample_t                oq;
        sample_t [TAPS-1:0]     di;
        sample_t [TAPS-1:0]     dq;
    } st_t;

    st_t st_d, st_q;

    // folded symmetric half-band: one product per coefficient pair
    function automatic sample_t hb(input sample_t [TAPS-1:0] w);
        acc_t a;
        a = HB_C1 * (sx(w[0])        + sx(w[TAPS-1]))
          + HB_C3 * (sx(w[2])        + sx(w[TAPS-3]))
          + HB_C5 * (sx(w[CTR-1])    + sx(w[CTR+1]))
          + HB_CC *  sx(w[CTR]);
        return rnd_sat(a, HB_SH);
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (in_valid) begin
            if (bypass) begin
                st_d.vld = 1'b1;
                st_d.oi  = in_i;
                st_d.oq  = in_q;
            end else begin
                st_d.di    = {st_q.di[TAPS-2:0], in_i};
                st_d.dq    = {st_q.dq[TAPS-2:0], in_q};
                st_d.phase = ~st_q.phase;
                if (!st_q.phase) begin
                    st_d.vld = 1'b1;
                    st_d.oi  = hb(st_d.di);
                    st_d.oq  = hb(st_d.dq);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_i     = st_q.oi;
    assign out_q     = st_q.oq;

    // R3: an output never appears without an input the cycle before
    p_valid_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R3: an active stage never emits on two consecutive input samples
    p_active_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !$past(bypass) && in_valid && out_valid) |=> !out_valid);

    // R4: a bypassed stage is a single register
    p_bypass_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && in_valid) |=> (out_valid && out_i == $past(in_i) && out_q == $past(in_q)));
endmodule

// File: rtl/ddc_chain.sv
`timescale 1ns/1ps
module ddc_chain
    import ddc_pkg::*;
#(
    parameter int PHASE_W  = 32,
    parameter int LUT_AW   = 10,
    parameter int N_STAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic signed [DW-1:0]  in_data,
    input  logic [PHASE_W-1:0]    cfg_fcw,
    input  logic                  cfg_mix_en,
    input  logic [N_STAGES-1:0]   cfg_stage_en,
    input  logic                  cfg_real_only,
    output logic                  out_valid,
    output logic signed [DW-1:0]  out_i,
    output logic signed [DW-1:0]  out_q
);
    sample_t nco_cos, nco_sin;

    logic [N_STAGES:0] vld;
    sample_t           si [N_STAGES+1];
    sample_t           sq [N_STAGES+1];

    ddc_nco #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW)) u_nco (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (in_valid),
        .fcw   (cfg_fcw),
        .cos_o (nco_cos),
        .sin_o (nco_sin)
    );

    ddc_mixer u_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .x         (in_data),
        .mix_en    (cfg_mix_en),
        .nco_cos   (nco_cos),
        .nco_sin   (nco_sin),
        .out_valid (vld[0]),
        .out_i     (si[0]),
        .out_q     (sq[0])
    );

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        ddc_hb_stage u_st (
            .clk       (clk),
            .rst_n     (rst_n),
            .bypass    (~cfg_stage_en[g]),
            .in_valid  (vld[g]),
            .in_i      (si[g]),
            .in_q      (sq[g]),
            .out_valid (vld[g+1]),
            .out_i     (si[g+1]),
            .out_q     (sq[g+1])
        );
    end

    assign out_valid = vld[N_STAGES];
    assign out_i     = si[N_STAGES];
    assign out_q     = cfg_real_only ? '0 : sq[N_STAGES];

    // R1: nothing leaves the chain in the first cycle out of reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/sim_ddc_chain.sv
`timescale 1ns/1ps
module sim_ddc_chain;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic [31:0]        cfg_fcw = '0;
    logic               cfg_mix_en = 1'b0;
    logic [3:0]         cfg_stage_en = '0;
    logic               cfg_real_only = 1'b0;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;
    int cyc   = 0;
    int n_cap = 0;
    int n_in  = 0;
    int cap_i [0:1023];
    int cap_q [0:1023];
    int cap_t [0:1023];
    int in_c  [0:1023];
    int in_v  [0:1023];

    ddc_chain u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_fcw(cfg_fcw), .cfg_mix_en(cfg_mix_en), .cfg_stage_en(cfg_stage_en),
        .cfg_real_only(cfg_real_only), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (out_valid && n_cap < 1024) begin
            cap_i[n_cap] = int'(out_i);
            cap_q[n_cap] = int'(out_q);
            cap_t[n_cap] = cyc;
            n_cap = n_cap + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        n_cap = 0;
        n_in  = 0;
        rst_n = 1'b1;
    endtask

    task automatic feed(input int v);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'(v);
        if (n_in < 1024) begin
            in_c[n_in] = cyc;
            in_v[n_in] = v;
        end
        n_in++;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic feed_tone(input real amp, input real w, input int n);
        for (int k = 0; k < n; k++) feed(int'(amp * $cos(w * k)));
        idle(40);
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        do_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        chk(out_i == 0 && out_q == 0, "R1 data after reset", int'(out_i), 0);
    endtask

    task automatic t_bypass();
        int bad_d, bad_q, bad_t;
        cfg_mix_en = 1'b0; cfg_stage_en = 4'b0000; cfg_real_only = 1'b0;
        do_reset();
        for (int k = 0; k < 20; k++) feed(k * 1000 - 7000);
        idle(10);
        chk(n_cap == 20, "R4 bypass count", n_cap, 20);
        bad_d = 0; bad_q = 0; bad_t = 0;
        for (int k = 0; k < 20; k++) begin
            if (cap_i[k] != in_v[k]) bad_d++;
            if (cap_q[k] != 0) bad_q++;
            if (cap_t[k] - in_c[k] != 5) bad_t++;
        end
        chk(bad_d == 0, "R4 bypass data", bad_d, 0);
        chk(bad_q == 0, "R5 bypass quadrature zero", bad_q, 0);
        chk(bad_t == 0, "R4 bypass latency", cap_t[0] - in_c[0], 5);
    endtask

    task automatic t_rate(input logic [3:0] en, input int n, input int exp);
        cfg_mix_en = 1'b0; cfg_stage_en = en;
        do_reset();
        for (int k = 0; k < n; k++) feed(100);
        idle(60);
        chk(n_cap == exp, "R3 decimation count", n_cap, exp);
    endtask

    task automatic t_stop();
        int pk;
        cfg_mix_en = 1'b0; cfg_stage_en = 4'b0001;
        do_reset();
        feed_tone(16000.0, 0.9 * 3.14159265358979, 200);
        pk = 0;
        for (int k = 10; k < n_cap; k++) if (iabs(cap_i[k]) > pk) pk = iabs(cap_i[k]);
        chk(pk <= 160, "R6 stopband peak", pk, 160);
    endtask

    task automatic t_pass();
        int pk;
        cfg_mix_en = 1'b0; cfg_stage_en = 4'b0001;
        do_reset();
        feed_tone(16000.0, 2.0 * 3.14159265358979 / 40.0, 200);
        pk = 0;
        for (int k = 10; k < n_cap; k++) if (iabs(cap_i[k]) > pk) pk = iabs(cap_i[k]);
        chk(pk >= 15200, "R7 passband peak", pk, 15200);
    endtask

    task automatic t_sat(input int sgn, input int exp);
        int pat [11];
        pat = '{1, 0, -1, 0, 1, 1, 1, 0, -1, 0, 1};
        cfg_mix_en = 1'b0; cfg_stage_en = 4'b0001;
        do_reset();
        for (int k = 0; k < 11; k++) feed(sgn * pat[k] * 32767);
        idle(5);
        chk(n_cap == 6 && cap_i[5] == exp, "R8 saturation", cap_i[5], exp);
    endtask

    task automatic t_nco(input bit real_only);
        int bad_i, bad_q, bad_s;
        cfg_mix_en = 1'b1; cfg_stage_en = 4'b0111; cfg_fcw = 32'h1000_0000;
        cfg_real_only = real_only;
        do_reset();
        feed_tone(20000.0, 2.0 * 3.14159265358979 / 16.0, 400);
        chk(n_cap == 50, "R2 output count", n_cap, 50);
        bad_i = 0; bad_q = 0; bad_s = 0;
        for (int k = 30; k < 50; k++) begin
            if (iabs(cap_i[k] - 10000) > 150) bad_i++;
            if (real_only ? (cap_q[k] != 0) : (iabs(cap_q[k]) > 150)) bad_q++;
            if (iabs(cap_i[k] - cap_i[k-1]) > 60) bad_s++;
        end
        chk(bad_i == 0, "R2 settled I", cap_i[49], 10000);
        if (real_only) chk(bad_q == 0, "R9 real-only Q zero", cap_q[49], 0);
        else begin
            chk(bad_q == 0, "R2 settled Q", cap_q[49], 0);
            chk(bad_s == 0, "R2 I stability", bad_s, 0);
        end
        cfg_real_only = 1'b0;
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_rate(4'b0001, 65, 33);
        t_rate(4'b0011, 64, 16);
        t_rate(4'b0111, 64, 8);
        t_rate(4'b1111, 64, 4);
        t_stop();
        t_pass();
        t_sat(1, 32767);
        t_sat(-1, -32768);
        t_nco(1'b0);
        t_nco(1'b1);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule